// File: doc/BRIEF.md
# External Bus Cycle Controller

This block sits between the processor core and the memory system. For every core access it decides whether the address is served by on-chip program memory or by the external bus. The decision depends on a memory-select bit latched at reset and a fixed on-chip address window. For external accesses it runs a three-state bus cycle: address, data, then completion. During that cycle it drives the address strobe, the read and write strobes, a width indicator and an instruction-fetch flag.

The core hands over a request on a valid/ready port. `req_ready` is high only while the controller is idle. The core keeps `req_valid` and every request field stable until a cycle with both `req_valid` and `req_ready` high. Ending the request that cycle or presenting the next one is the core's choice. A request is taken at the clock edge where both are high, and the controller gives no back-pressure other than dropping `req_ready`. `req_done` pulses for one cycle when the access has finished.

The cycle width is 8 bits unless a configuration bit lets an external width pin pick 16 bits for each cycle. A 16-bit access that ends up with an 8-bit cycle runs as two byte cycles. The address strobe works in one of two styles chosen by configuration: a short high latch-enable pulse, or an active-low address-valid level that lasts for the whole external access.

Top module: `ext_bus_ctl`

## Requirements
- R1: If `mem_sel` is 1 and the request address lies in 0x2000..0x3FFF inclusive, the access is on-chip. In the cycle after acceptance `onchip_o` and `req_done` are 1. In that cycle the read, write and fetch outputs stay 0 and the strobe stays in its idle level.
- R2: If `mem_sel` is 0, addresses in 0x2000..0x3FFF go to the external bus. Addresses outside that window always go to the external bus, whatever `mem_sel` is.
- R3: If `cfg_dyn_width` is 1, `width_pin` is sampled at the clock edge that ends the address state: 1 selects a 16-bit cycle, 0 an 8-bit cycle. `bus_wide_o` shows the result during the data and completion states and ignores later changes of the pin.
- R4: If `cfg_dyn_width` is 0, every external cycle is 8 bits wide (`bus_wide_o` = 0) for any value of `width_pin`.
- R5: An external cycle takes three clock cycles: address, data and completion. `bus_rd_o` or `bus_wr_o` is high in the data state. `req_done` is high for one cycle, in the completion state of the last cycle of the access.
- R6: With `cfg_adv` = 0 (latch-enable style), `strobe_o` is 1 only during the address state of an external cycle and 0 at all other times.
- R7: With `cfg_adv` = 1 (address-valid style), `strobe_o` is 0 throughout every state of an external access and 1 when idle and during on-chip accesses.
- R8: `fetch_o` is 1 in all three states of an external read with `req_fetch` = 1. It is 0 for on-chip accesses, for writes and when idle.
- R9: If `req_word` = 1 and the cycle width is 8 bits, the access runs as two byte cycles back to back. `bus_addr_o` has bit 0 cleared in the first cycle and set in the second, and `req_done` appears only in the completion state of the second. If the width is 16 bits, a single cycle drives the request address unchanged.
- R10: `req_ready` is 1 only when idle. A request held valid while the controller is busy is accepted only after the controller returns to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Core request valid |
| req_ready | output | 1 | Controller can take a request (idle) |
| req_addr | input | 16 | Request address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_fetch | input | 1 | Read is an instruction fetch |
| req_word | input | 1 | 16-bit access |
| req_done | output | 1 | One-cycle completion pulse |
| mem_sel | input | 1 | Memory-select bit latched at reset |
| cfg_dyn_width | input | 1 | 1 = width pin picks cycle width |
| cfg_adv | input | 1 | 1 = address-valid strobe style, 0 = latch-enable pulse |
| width_pin | input | 1 | Per-cycle width pin, 1 = 16-bit |
| onchip_o | output | 1 | On-chip access in progress |
| strobe_o | output | 1 | Address strobe (style per `cfg_adv`) |
| bus_rd_o | output | 1 | External read strobe |
| bus_wr_o | output | 1 | External write strobe |
| bus_wide_o | output | 1 | Current cycle is 16 bits wide |
| fetch_o | output | 1 | External instruction fetch in progress |
| bus_addr_o | output | 16 | External bus address |

## Verification
Counting from the clock edge that accepts a request, the address state outputs (strobe pulse, address, fetch flag) are due one cycle later. The data-state outputs (read or write strobe, width) are due two cycles later, and completion with `req_done` three cycles later. A second byte cycle repeats this pattern shifted by three cycles, and an on-chip completion is due one cycle after acceptance. The bench changes inputs on falling edges and reads outputs on the falling edge of each of those cycles in turn. It changes `width_pin` after the sampling edge to show that the width is held.

// File: rtl/ebc_pkg.sv
package ebc_pkg;
  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_ONCHIP = 3'd1,
    PH_ADDR   = 3'd2,
    PH_DATA   = 3'd3,
    PH_DONE   = 3'd4
  } phase_t;
endpackage

// File: rtl/ebc_region_decode.sv
module ebc_region_decode #(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] WIN_LO = 'h2000,
  parameter logic [ADDR_W-1:0] WIN_HI = 'h3FFF
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              mem_sel,
  output logic              onchip
);
  logic in_window;
  always_comb begin
    in_window = (addr >= WIN_LO) && (addr <= WIN_HI);
    onchip    = mem_sel && in_window;
  end
endmodule

// File: rtl/ebc_seq.sv
module ebc_seq
  import ebc_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  input  logic              req_fetch,
  input  logic              req_word,
  input  logic              onchip,
  input  logic              cfg_dyn_width,
  input  logic              width_pin,
  output logic              req_done,
  output phase_t            phase,
  output logic [ADDR_W-1:0] addr_out,
  output logic              write_q,
  output logic              fetch_q,
  output logic              wide_q
);
  logic [ADDR_W-1:0] addr_q;
  logic              word_q;
  logic              byte_hi;
  logic              split_more;

  assign req_ready  = (phase == PH_IDLE);
  assign split_more = word_q && !wide_q && !byte_hi;
  assign req_done   = (phase == PH_ONCHIP) || ((phase == PH_DONE) && !split_more);
  assign addr_out   = word_q ? {addr_q[ADDR_W-1:1], byte_hi} : addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase   <= PH_IDLE;
      addr_q  <= '0;
      write_q <= 1'b0;
      fetch_q <= 1'b0;
      word_q  <= 1'b0;
      wide_q  <= 1'b0;
      byte_hi <= 1'b0;
    end else begin
      unique case (phase)
        PH_IDLE: if (req_valid) begin
          addr_q  <= req_addr;
          write_q <= req_write;
          fetch_q <= req_fetch;
          word_q  <= req_word;
          byte_hi <= 1'b0;
          phase   <= onchip ? PH_ONCHIP : PH_ADDR;
        end
        PH_ONCHIP: phase <= PH_IDLE;
        PH_ADDR: begin
          wide_q <= cfg_dyn_width && width_pin;
          phase  <= PH_DATA;
        end
        PH_DATA: phase <= PH_DONE;
        PH_DONE: begin
          if (split_more) begin
            byte_hi <= 1'b1;
            phase   <= PH_ADDR;
          end else begin
            phase <= PH_IDLE;
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  // R3: width chosen in the address state is held into completion
  a_r3_width_held: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_DONE) |-> $stable(wide_q));
  // R4: fixed width configuration never yields a wide cycle
  a_r4_fixed_narrow: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_DATA && !$past(cfg_dyn_width)) |-> !wide_q);
  // R5: completion is a single-cycle pulse
  a_r5_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    req_done |=> !req_done);
  // R10: a busy controller does not change its captured request
  a_r10_busy_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_DATA) |-> $stable(addr_q));
endmodule

// File: rtl/ebc_out_gen.sv
module ebc_out_gen
  import ebc_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  phase_t phase,
  input  logic   cfg_adv,
  input  logic   write_q,
  input  logic   fetch_q,
  input  logic   wide_q,
  output logic   onchip_o,
  output logic   strobe_o,
  output logic   bus_rd_o,
  output logic   bus_wr_o,
  output logic   bus_wide_o,
  output logic   fetch_o
);
  logic ext_busy;
  logic in_data;

  always_comb begin
    ext_busy   = (phase == PH_ADDR) || (phase == PH_DATA) || (phase == PH_DONE);
    in_data    = (phase == PH_DATA);
    onchip_o   = (phase == PH_ONCHIP);
    strobe_o   = cfg_adv ? !ext_busy : (phase == PH_ADDR);
    bus_rd_o   = in_data && !write_q;
    bus_wr_o   = in_data && write_q;
    bus_wide_o = (in_data || (phase == PH_DONE)) && wide_q;
    fetch_o    = ext_busy && fetch_q && !write_q;
  end

  // R8: fetch flag stays up until the completion state
  a_r8_fetch_held: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_o && phase != PH_DONE) |=> fetch_o);
  // R1: on-chip work never shows bus strobes
  a_r1_onchip_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    onchip_o |-> !(bus_rd_o || bus_wr_o || fetch_o));
  // R5: read and write strobes are exclusive
  a_r5_rw_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_rd_o && bus_wr_o));
endmodule

// File: rtl/ext_bus_ctl.sv
module ext_bus_ctl
  import ebc_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] WIN_LO = 'h2000,
  parameter logic [ADDR_W-1:0] WIN_HI = 'h3FFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  input  logic              req_fetch,
  input  logic              req_word,
  output logic              req_done,
  input  logic              mem_sel,
  input  logic              cfg_dyn_width,
  input  logic              cfg_adv,
  input  logic              width_pin,
  output logic              onchip_o,
  output logic              strobe_o,
  output logic              bus_rd_o,
  output logic              bus_wr_o,
  output logic              bus_wide_o,
  output logic              fetch_o,
  output logic [ADDR_W-1:0] bus_addr_o
);
  logic   onchip_hit;
  phase_t phase;
  logic   write_q, fetch_q, wide_q;

  ebc_region_decode #(.ADDR_W(ADDR_W), .WIN_LO(WIN_LO), .WIN_HI(WIN_HI)) u_dec (
    .addr(req_addr), .mem_sel(mem_sel), .onchip(onchip_hit)
  );

  ebc_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_write(req_write), .req_fetch(req_fetch),
    .req_word(req_word), .onchip(onchip_hit), .cfg_dyn_width(cfg_dyn_width),
    .width_pin(width_pin), .req_done(req_done), .phase(phase),
    .addr_out(bus_addr_o), .write_q(write_q), .fetch_q(fetch_q), .wide_q(wide_q)
  );

  ebc_out_gen u_out (
    .clk(clk), .rst_n(rst_n), .phase(phase), .cfg_adv(cfg_adv),
    .write_q(write_q), .fetch_q(fetch_q), .wide_q(wide_q),
    .onchip_o(onchip_o), .strobe_o(strobe_o), .bus_rd_o(bus_rd_o),
    .bus_wr_o(bus_wr_o), .bus_wide_o(bus_wide_o), .fetch_o(fetch_o)
  );

  // R6: latch-enable pulse lasts a single cycle
  a_r6_ale_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_adv && $past(!cfg_adv) && strobe_o) |=> !strobe_o);
  // R10: no request is taken while busy
  a_r10_ready_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready && !req_valid) |=> req_ready);
endmodule

// File: tb/ext_bus_ctl_tb_top.sv
`timescale 1ns/1ps
module ext_bus_ctl_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 0, req_write = 0, req_fetch = 0, req_word = 0;
  logic [15:0] req_addr = '0;
  logic mem_sel = 0, cfg_dyn_width = 0, cfg_adv = 0, width_pin = 0;
  logic req_ready, req_done, onchip_o, strobe_o, bus_rd_o, bus_wr_o, bus_wide_o, fetch_o;
  logic [15:0] bus_addr_o;
  int checks = 0;
  int fails = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;

  ext_bus_ctl dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_write(req_write), .req_fetch(req_fetch),
    .req_word(req_word), .req_done(req_done), .mem_sel(mem_sel),
    .cfg_dyn_width(cfg_dyn_width), .cfg_adv(cfg_adv), .width_pin(width_pin),
    .onchip_o(onchip_o), .strobe_o(strobe_o), .bus_rd_o(bus_rd_o),
    .bus_wr_o(bus_wr_o), .bus_wide_o(bus_wide_o), .fetch_o(fetch_o),
    .bus_addr_o(bus_addr_o)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // present a request at a falling edge; returns at the falling edge after acceptance
  task automatic issue(input logic [15:0] a, input logic w, input logic f, input logic wd);
    req_addr = a; req_write = w; req_fetch = f; req_word = wd; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic t_reset;
    chk(req_ready, 1, "R10 ready after reset");
    chk({strobe_o, bus_rd_o, bus_wr_o, fetch_o, req_done}, 0, "R6 idle outputs after reset");
  endtask

  task automatic t_onchip;
    mem_sel = 1; cfg_adv = 0;
    @(negedge clk);
    issue(16'h2100, 0, 1, 0);
    chk({onchip_o, req_done}, 2'b11, "R1 on-chip done");
    chk({strobe_o, bus_rd_o, fetch_o}, 0, "R1 R8 on-chip quiet");
    @(negedge clk);
    chk(req_ready, 1, "R1 back to idle");
    cfg_adv = 1;
    @(negedge clk);
    issue(16'h3FFF, 0, 0, 0);
    chk({onchip_o, strobe_o}, 2'b11, "R7 on-chip keeps strobe idle high");
    @(negedge clk);
  endtask

  task automatic t_ext_fetch;
    mem_sel = 0; cfg_adv = 0; cfg_dyn_width = 1; width_pin = 1;
    @(negedge clk);
    issue(16'h2100, 0, 1, 0);
    chk({onchip_o, strobe_o, fetch_o, req_ready}, 4'b0110, "R2 R6 R8 address state");
    chk(bus_addr_o, 16'h2100, "R2 address driven");
    @(negedge clk);
    width_pin = 0;
    chk({strobe_o, bus_rd_o, bus_wide_o, fetch_o}, 4'b0111, "R3 R5 data state");
    @(negedge clk);
    chk({bus_wide_o, fetch_o, req_done, bus_rd_o}, 4'b1110, "R3 R5 R8 completion");
    @(negedge clk);
    chk({req_ready, fetch_o, strobe_o}, 3'b100, "R8 idle after cycle");
  endtask

  task automatic t_adv_write;
    mem_sel = 1; cfg_adv = 1; cfg_dyn_width = 0;
    @(negedge clk);
    issue(16'h8000, 1, 1, 0);
    chk({onchip_o, strobe_o, fetch_o}, 0, "R2 R7 R8 outside window external");
    @(negedge clk);
    chk({strobe_o, bus_wr_o, bus_rd_o}, 3'b010, "R7 R5 write data state");
    @(negedge clk);
    chk({strobe_o, req_done}, 2'b01, "R7 low through completion");
    @(negedge clk);
    chk(strobe_o, 1, "R7 high after cycle");
  endtask

  task automatic t_split(input logic dyn, input logic pin);
    mem_sel = 0; cfg_adv = 0; cfg_dyn_width = dyn; width_pin = pin;
    @(negedge clk);
    issue(16'h4002, 0, 0, 1);
    chk({strobe_o, bus_addr_o}, {1'b1, 16'h4002}, "R9 low byte first");
    @(negedge clk);
    chk(bus_wide_o, 0, "R4 R3 narrow cycle");
    @(negedge clk);
    chk(req_done, 0, "R9 no done after first byte");
    @(negedge clk);
    chk({strobe_o, bus_addr_o}, {1'b1, 16'h4003}, "R9 high byte second");
    @(negedge clk);
    chk({bus_rd_o, bus_wide_o}, 2'b10, "R4 R9 second data");
    @(negedge clk);
    chk(req_done, 1, "R9 done after second byte");
    @(negedge clk);
  endtask

  task automatic t_wide_word;
    mem_sel = 0; cfg_adv = 0; cfg_dyn_width = 1; width_pin = 1;
    @(negedge clk);
    issue(16'h5006, 0, 0, 1);
    chk(bus_addr_o, 16'h5006, "R9 wide address unchanged");
    @(negedge clk);
    chk(bus_wide_o, 1, "R3 wide cycle");
    @(negedge clk);
    chk(req_done, 1, "R9 single wide cycle done");
    @(negedge clk);
  endtask

  task automatic t_busy;
    mem_sel = 0; cfg_adv = 0; cfg_dyn_width = 0;
    @(negedge clk);
    issue(16'h6000, 0, 0, 0);
    req_addr = 16'h9000; req_valid = 1'b1;
    chk(req_ready, 0, "R10 not ready in address state");
    @(negedge clk);
    chk({req_ready, bus_addr_o}, {1'b0, 16'h6000}, "R10 busy keeps first request");
    @(negedge clk);
    @(negedge clk);
    chk(req_ready, 1, "R10 ready when idle");
    @(negedge clk);
    req_valid = 1'b0;
    chk({strobe_o, bus_addr_o}, {1'b1, 16'h9000}, "R10 held request taken later");
    repeat (3) @(negedge clk);
  endtask

  task automatic finish_run;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d expected below 20000 cycles", cyc);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_onchip();
    t_ext_fetch();
    t_adv_write();
    t_split(1'b0, 1'b1);
    t_split(1'b1, 1'b0);
    t_wide_word();
    t_busy();
    finish_run();
  end
endmodule